// File: doc/BRIEF.md
# End-of-Block Check Word Sequencer

This block times the closing bytes of a block being written to tape. A single end-of-block strobe arms a small one-shot counter. From then on the counter advances once for each write-phase clock strobe. When a set number of strobes has been counted, the block sends a one-cycle select pulse to the write-data path, so that the check word takes the byte slot that follows. Counting goes on to a second, later number. There the block sends a one-cycle write-reset pulse to the processor and the transport, and it falls back to idle by itself.

The check word is not computed. It comes from a static configuration input, which stands in for fixed switch settings. In the default variant the block captures that value when a sequence is accepted and holds it until the next accepted start. A parameter selects instead a variant that passes the input straight through.

Top module: `eob_crc_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `crc_sel` and `wr_reset` are 0, and in the latched variant `chk_word` is 0. A reset in the middle of a sequence abandons that sequence.
- R2: While idle, strobes on `wclk_stb` produce no pulse on either output.
- R3: `crc_sel` is high for the one clock cycle after the edge that counts the INS_COUNT-th strobe (default 3) since the accepted start.
- R4: `wr_reset` is high for the one clock cycle after the edge that counts the END_COUNT-th strobe (default 8) since the accepted start.
- R5: The edge that counts the END_COUNT-th strobe returns the block to idle. Later strobes give no pulse until a new `eob_stb` arrives.
- R6: An `eob_stb` that arrives while a sequence is running is ignored. This includes one in the same cycle as the final strobe. The pulse positions stay those of the first start.
- R7: A `wclk_stb` in the same cycle as an accepted `eob_stb` is not counted.
- R8: In the latched variant (LATCH_WORD=1), `chk_word` shows the value of `chk_cfg` sampled at the edge that accepts a start. Changes to `chk_cfg` after that edge do not affect it until the next accepted start.
- R9: `crc_sel` and `wr_reset` never stay high for two cycles in a row, and they are never high together.
- R10: Only cycles with `wclk_stb` high advance the count. Idle cycles between strobes do not move the pulse positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eob_stb | input | 1 | End-of-block strobe; starts a sequence when idle |
| wclk_stb | input | 1 | Write-phase clock strobe, one cycle per byte slot |
| chk_cfg | input | WORD_W | Static configured check-word value |
| crc_sel | output | 1 | One-cycle pulse telling the write path to insert the check word |
| chk_word | output | WORD_W | Check word presented to the write path |
| wr_reset | output | 1 | One-cycle write-reset pulse at the end of the sequence |

## Verification
The bench builds the block with its defaults: an 8-bit word, insertion after the third strobe, write-reset after the eighth, and the latched word variant. These values make the whole sequence short enough that one table can cover two complete runs. One run has gaps between strobes and the other has back-to-back strobes, so both R10 and the plain counting path are exercised. With the latched variant, the bench can change `chk_cfg` in the middle of a run and watch `chk_word` at the port. The short run length also leaves room for directed cases of a start that lands on the final strobe and of a reset in the middle of a sequence.

// File: rtl/eob_seq_pkg.sv
package eob_seq_pkg;

   // Smallest counter width that holds 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_mode_e;

endpackage

// File: rtl/eob_strobe_counter.sv
module eob_strobe_counter
   import eob_seq_pkg::*;
#(
   parameter int unsigned END_COUNT = 8,
   localparam int unsigned CNT_W    = cnt_width(END_COUNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             strobe,
   output logic             running,
   output logic             start_ok,
   output logic             step,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(END_COUNT - 1);

   seq_mode_e mode_q;

   assign running  = (mode_q == SEQ_RUN);
   assign start_ok = start_req && !running;
   assign step     = strobe && running;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= SEQ_IDLE;
         count  <= '0;
      end else if (start_ok) begin
         mode_q <= SEQ_RUN;
         count  <= '0;
      end else if (step) begin
         if (count == LAST_IDX) begin
            mode_q <= SEQ_IDLE;
            count  <= '0;
         end else begin
            count <= count + 1'b1;
         end
      end
   end

   // R5: the count never reaches the terminal value while running
   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count < CNT_W'(END_COUNT));

   // R6: a start request while running leaves the count alone
   assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start_req && !strobe) |=> $stable(count));

   // R2: idle holds the count at zero
   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (count == '0));

endmodule

// File: rtl/eob_event_decode.sv
module eob_event_decode
   import eob_seq_pkg::*;
#(
   parameter int unsigned INS_COUNT = 3,
   parameter int unsigned END_COUNT = 8,
   localparam int unsigned CNT_W    = cnt_width(END_COUNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] count,
   output logic             ins_pulse,
   output logic             end_pulse
);

   localparam logic [CNT_W-1:0] INS_IDX = CNT_W'(INS_COUNT - 1);
   localparam logic [CNT_W-1:0] END_IDX = CNT_W'(END_COUNT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_pulse <= 1'b0;
         end_pulse <= 1'b0;
      end else begin
         ins_pulse <= step && (count == INS_IDX);
         end_pulse <= step && (count == END_IDX);
      end
   end

   // R9: single-cycle pulses, never coincident
   assert_ins_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ins_pulse |=> !ins_pulse);
   assert_end_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      end_pulse |=> !end_pulse);
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ins_pulse && end_pulse));

   // R3, R4: each pulse follows a counted strobe
   assert_ins_after_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ins_pulse) |-> $past(step));
   assert_end_after_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_pulse) |-> $past(step));

endmodule

// File: rtl/eob_word_source.sv
module eob_word_source #(
   parameter int unsigned WORD_W     = 8,
   parameter bit          LATCH_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              running,
   input  logic [WORD_W-1:0] cfg,
   output logic [WORD_W-1:0] word
);

   generate
      if (LATCH_WORD) begin : g_latched
         logic [WORD_W-1:0] word_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (capture) begin
               word_q <= cfg;
            end
         end

         assign word = word_q;

         // R8: the word holds steady while a sequence runs
         assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (running && !capture) |=> $stable(word));
         // R8: an accepted start loads the configured value
         assert_word_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
            capture |=> (word == $past(cfg)));
      end else begin : g_passthru
         assign word = cfg;
      end
   endgenerate

endmodule

// File: rtl/eob_crc_sequencer.sv
module eob_crc_sequencer
   import eob_seq_pkg::*;
#(
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned INS_COUNT  = 3,
   parameter int unsigned END_COUNT  = 8,
   parameter bit          LATCH_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eob_stb,
   input  logic              wclk_stb,
   input  logic [WORD_W-1:0] chk_cfg,
   output logic              crc_sel,
   output logic [WORD_W-1:0] chk_word,
   output logic              wr_reset
);

   localparam int unsigned CNT_W = cnt_width(END_COUNT);

   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("eob_crc_sequencer: WORD_W must be at least 1");
      end
      if (INS_COUNT < 1) begin : g_bad_ins
         $error("eob_crc_sequencer: INS_COUNT must be at least 1");
      end
      if (END_COUNT <= INS_COUNT) begin : g_bad_end
         $error("eob_crc_sequencer: END_COUNT must exceed INS_COUNT");
      end
   endgenerate

   logic             running;
   logic             start_ok;
   logic             step;
   logic [CNT_W-1:0] count;

   eob_strobe_counter #(
      .END_COUNT (END_COUNT)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (eob_stb),
      .strobe    (wclk_stb),
      .running   (running),
      .start_ok  (start_ok),
      .step      (step),
      .count     (count)
   );

   eob_event_decode #(
      .INS_COUNT (INS_COUNT),
      .END_COUNT (END_COUNT)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .count     (count),
      .ins_pulse (crc_sel),
      .end_pulse (wr_reset)
   );

   eob_word_source #(
      .WORD_W     (WORD_W),
      .LATCH_WORD (LATCH_WORD)
   ) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (start_ok),
      .running (running),
      .cfg     (chk_cfg),
      .word    (chk_word)
   );

   // R2: no pulse ever follows a strobe seen while idle
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !eob_stb) |=> !(crc_sel || wr_reset));

   // R7: the strobe that shares a cycle with the start is not counted
   assert_start_strobe_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (count == '0));

endmodule

// File: tb/eob_crc_sequencer_test.sv
`timescale 1ns/1ps
module eob_crc_sequencer_test;

   localparam int NV = 24;
   // vector: {eob, wclk, cfg[7:0], exp_crc, exp_wr, exp_word[7:0]}
   localparam logic [NV-1:0][19:0] VEC = {
      // index 0 is the last element of this list
      {1'b0,1'b1,8'hFF,1'b0,1'b1,8'h3C}, // 23 R4 eighth back-to-back strobe
      {1'b0,1'b1,8'hFF,1'b0,1'b0,8'h3C}, // 22
      {1'b0,1'b1,8'hFF,1'b0,1'b0,8'h3C}, // 21
      {1'b0,1'b1,8'hFF,1'b0,1'b0,8'h3C}, // 20 R8 cfg change ignored
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'h3C}, // 19
      {1'b0,1'b1,8'h3C,1'b1,1'b0,8'h3C}, // 18 R3 third strobe
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'h3C}, // 17
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'h3C}, // 16
      {1'b1,1'b0,8'h3C,1'b0,1'b0,8'h3C}, // 15 R8 new start loads word
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 14 R5 idle again
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 13 R5 strobe after end
      {1'b0,1'b1,8'h3C,1'b0,1'b1,8'hA5}, // 12 R4 eighth strobe
      {1'b1,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 11 R6 start while running
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 10
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 9
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 8
      {1'b0,1'b0,8'h3C,1'b0,1'b0,8'hA5}, // 7 R9 pulse gone
      {1'b0,1'b1,8'h3C,1'b1,1'b0,8'hA5}, // 6 R3 third strobe
      {1'b1,1'b0,8'h3C,1'b0,1'b0,8'hA5}, // 5 R6 start ignored
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 4
      {1'b0,1'b0,8'h3C,1'b0,1'b0,8'hA5}, // 3 R10 gap
      {1'b0,1'b1,8'h3C,1'b0,1'b0,8'hA5}, // 2 R8 cfg change ignored
      {1'b1,1'b1,8'hA5,1'b0,1'b0,8'hA5}, // 1 R7 start with strobe
      {1'b0,1'b1,8'hA5,1'b0,1'b0,8'h00}  // 0 R2 strobe while idle
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       eob_stb = 1'b0;
   logic       wclk_stb = 1'b0;
   logic [7:0] chk_cfg = 8'h00;
   logic       crc_sel;
   logic [7:0] chk_word;
   logic       wr_reset;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   eob_crc_sequencer uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .eob_stb  (eob_stb),
      .wclk_stb (wclk_stb),
      .chk_cfg  (chk_cfg),
      .crc_sel  (crc_sel),
      .chk_word (chk_word),
      .wr_reset (wr_reset)
   );

   task automatic check(input string req, input logic crc_e, input logic wr_e,
                        input logic [7:0] word_e);
      n_vec++;
      if (crc_sel !== crc_e || wr_reset !== wr_e || chk_word !== word_e) begin
         n_bad++;
         $display("FAIL %s: got crc=%b wr=%b word=%h, expected crc=%b wr=%b word=%h",
                  req, crc_sel, wr_reset, chk_word, crc_e, wr_e, word_e);
      end
   endtask

   task automatic apply(input logic e, input logic w, input logic [7:0] c);
      @(negedge clk);
      eob_stb  = e;
      wclk_stb = w;
      chk_cfg  = c;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      check("R1", 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", 1'b0, 1'b0, 8'h00);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][19], VEC[i][18], VEC[i][17:10]);
         check($sformatf("R3/R4 vector %0d", i), VEC[i][9], VEC[i][8], VEC[i][7:0]);
      end

      // R6: start arriving with the final strobe is ignored
      apply(1'b1, 1'b0, 8'h5A);
      check("R8", 1'b0, 1'b0, 8'h5A);
      for (int k = 0; k < 7; k++) begin
         apply(1'b0, 1'b1, 8'h5A);
         check("R3", (k == 2), 1'b0, 8'h5A);
      end
      apply(1'b1, 1'b1, 8'h11);
      check("R6", 1'b0, 1'b1, 8'h5A);
      apply(1'b0, 1'b1, 8'h11);
      check("R6", 1'b0, 1'b0, 8'h5A);

      // R1: reset mid-sequence abandons the run
      apply(1'b1, 1'b0, 8'h77);
      apply(1'b0, 1'b1, 8'h77);
      apply(1'b0, 1'b1, 8'h77);
      @(negedge clk);
      rst_n = 1'b0;
      wclk_stb = 1'b0;
      eob_stb = 1'b0;
      @(posedge clk);
      #1;
      check("R1", 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
         apply(1'b0, 1'b1, 8'h77);
         check("R1", 1'b0, 1'b0, 8'h00);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule